// File: doc/BRIEF.md
# Parity-Checked Two-Way Bus Transceiver

This block joins two 8-bit buses, a near side (R) and a far side (T), and passes data in either direction. Traffic that goes toward the far side carries an extra parity bit. The block produces that bit with a balanced XOR tree, using odd parity. Traffic that arrives from the far side is checked by a second tree over all nine bits, the data plus the parity bit. A failed check is stored in a sticky flag register on the rising clock edge. The flag is brought out as the pull-low enable of an open-drain error pin, and it stays set until a synchronous clear.

Each port has its own active-low drive enable. Tri-state pads are modelled as separate input, output and output-enable signals. When both enables are low at once, the block drives both sides and deliberately sends the wrong (even) parity bit toward the far side. A receiver on that bus can then be tested for error detection.

Top module: `parity_xcvr`

## Requirements
- R1: With `t_drv_n`=0 and `r_drv_n`=1 (transmit), `t_out` equals `r_in`, `t_oe`=1 and `r_oe`=0.
- R2: In transmit, `t_par_out` is chosen so that the nine bits {`t_par_out`, `t_out`} hold an odd number of ones.
- R3: With `r_drv_n`=0 and `t_drv_n`=1 (receive), `r_out` equals `t_in`, `r_oe`=1 and `t_oe`=0.
- R4: With both enables high (idle), `t_oe`=`r_oe`=0, and `t_out`, `t_par_out` and `r_out` are driven 0.
- R5: With both enables low (diagnostic), `t_oe`=`r_oe`=1, `t_out`=`r_in`, `r_out`=`t_in`, and `t_par_out` is inverted, so {`t_par_out`, `t_out`} holds an even number of ones.
- R6: In receive, a rising clock edge with an even number of ones in {`t_par_in`, `t_in`} and `clr_n`=1 sets the flag. `err_pull_low` reads 1 after that edge.
- R7: Once set, the flag stays set through later edges, including edges with good parity and edges in any mode, until a clear.
- R8: `clr_n`=0 clears the flag on the next rising edge. It wins over a simultaneous parity failure.
- R9: `rst_n`=0 clears the flag at once, without waiting for a clock edge.
- R10: In the transmit, idle and diagnostic modes, the flag is not changed by the values on `t_in` or `t_par_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_drv_n | input | 1 | Active-low enable for driving the far-side port |
| r_drv_n | input | 1 | Active-low enable for driving the near-side port |
| clr_n | input | 1 | Synchronous active-low flag clear |
| r_in | input | 8 | Near-side bus value read from the pads |
| r_out | output | 8 | Near-side value to drive |
| r_oe | output | 1 | Near-side pad output enable |
| t_in | input | 8 | Far-side bus data read from the pads |
| t_par_in | input | 1 | Far-side parity bit read from the pad |
| t_out | output | 8 | Far-side data to drive |
| t_par_out | output | 1 | Far-side parity bit to drive |
| t_oe | output | 1 | Far-side pad output enable (data and parity) |
| err_pull_low | output | 1 | 1 pulls the open-drain error pin low (flag set) |

## Verification
Transmit is swept over all 256 data words, which exposes any wrong or missing tree leaf or a parity of the wrong sense. The diagnostic mode uses the same sweep and must give the opposite parity on every word. Receive is swept over all 512 combinations of nine bits, with a clear between them. This separates words that must set the flag from words that must not, and it catches a checker that ignores the parity bit. Directed sequences then cover the following cases:
- a good word after a bad one, to show the flag is sticky;
- bad parity in each non-receive mode, to show the flag holds;
- clear during a bad word, for clear priority;
- reset with no clock edge, for the asynchronous clear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_TX   = 2'b01,
    MODE_RX   = 2'b10,
    MODE_DIAG = 2'b11
  } xcvr_mode_e;

  // Active-low enables in, operating mode out.
  function automatic xcvr_mode_e decode_mode(input logic t_drv_n, input logic r_drv_n);
    unique case ({t_drv_n, r_drv_n})
      2'b01:   return MODE_TX;
      2'b10:   return MODE_RX;
      2'b00:   return MODE_DIAG;
      default: return MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/xor_tree.sv
// Balanced XOR reduction laid out as a heap: leaves at [P..2P-1], root at [1].
module xor_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits,
  output logic         odd_ones
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int P      = 1 << LEVELS;

  logic [2*P-1:1] heap;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign heap[P+i] = bits[i];
    end else begin : g_pad
      assign heap[P+i] = 1'b0;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    assign heap[k] = heap[2*k] ^ heap[2*k+1];
  end

  assign odd_ones = heap[1];
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import xcvr_pkg::*;
(
  input  logic t_drv_n,
  input  logic r_drv_n,
  output logic t_oe,
  output logic r_oe,
  output logic invert_par,
  output logic capture_en
);
  xcvr_mode_e mode;

  always_comb begin
    mode       = decode_mode(t_drv_n, r_drv_n);
    t_oe       = (mode == MODE_TX) || (mode == MODE_DIAG);
    r_oe       = (mode == MODE_RX) || (mode == MODE_DIAG);
    invert_par = (mode == MODE_DIAG);
    capture_en = (mode == MODE_RX);
  end
endmodule

// File: rtl/err_flag.sv
module err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic capture_en,
  input  logic bad_parity,
  output logic flag
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = !clr_n || capture_en;
    if (!clr_n) flag_d = 1'b0;
    else        flag_d = flag | bad_parity;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && bad_parity && clr_n) |=> flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr_n) |=> flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !flag);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && clr_n) |=> $stable(flag));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         t_drv_n,
  input  logic         r_drv_n,
  input  logic         clr_n,
  input  logic [W-1:0] r_in,
  output logic [W-1:0] r_out,
  output logic         r_oe,
  input  logic [W-1:0] t_in,
  input  logic         t_par_in,
  output logic [W-1:0] t_out,
  output logic         t_par_out,
  output logic         t_oe,
  output logic         err_pull_low
);
  localparam int CHK_W = W + 1;

  logic t_oe_i, r_oe_i, invert_par, capture_en;
  logic gen_odd, chk_odd, flag;

  mode_decode u_mode (
    .t_drv_n    (t_drv_n),
    .r_drv_n    (r_drv_n),
    .t_oe       (t_oe_i),
    .r_oe       (r_oe_i),
    .invert_par (invert_par),
    .capture_en (capture_en)
  );

  xor_tree #(.N(W)) u_gen (
    .bits     (r_in),
    .odd_ones (gen_odd)
  );

  xor_tree #(.N(CHK_W)) u_chk (
    .bits     ({t_par_in, t_in}),
    .odd_ones (chk_odd)
  );

  err_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .capture_en (capture_en),
    .bad_parity (!chk_odd),
    .flag       (flag)
  );

  always_comb begin
    t_oe         = t_oe_i;
    r_oe         = r_oe_i;
    t_out        = t_oe_i ? r_in : '0;
    t_par_out    = t_oe_i & (~gen_odd ^ invert_par);
    r_out        = r_oe_i ? t_in : '0;
    err_pull_low = flag;
  end

  assert_tx_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_drv_n && r_drv_n) |-> (^{t_par_out, t_out}));
  assert_diag_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_drv_n && !r_drv_n) |-> !(^{t_par_out, t_out}));
  assert_idle_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_drv_n && r_drv_n) |-> (!t_oe && !r_oe && t_out == '0 && r_out == '0));
  assert_rx_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_drv_n && !r_drv_n) |-> (r_out == t_in && r_oe && !t_oe));
endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  logic clk = 1'b0;
  logic rst_n, t_drv_n, r_drv_n, clr_n, t_par_in;
  logic [7:0] r_in, t_in;
  logic [7:0] r_out, t_out;
  logic r_oe, t_oe, t_par_out, err_pull_low;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  parity_xcvr uut (
    .clk(clk), .rst_n(rst_n), .t_drv_n(t_drv_n), .r_drv_n(r_drv_n), .clr_n(clr_n),
    .r_in(r_in), .r_out(r_out), .r_oe(r_oe),
    .t_in(t_in), .t_par_in(t_par_in), .t_out(t_out), .t_par_out(t_par_out),
    .t_oe(t_oe), .err_pull_low(err_pull_low)
  );

  function automatic int ones(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_flag();
    t_drv_n = 1'b1; r_drv_n = 1'b1; clr_n = 1'b0;
    tick();
    clr_n = 1'b1;
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; t_drv_n = 1'b1; r_drv_n = 1'b1; clr_n = 1'b1;
    r_in = '0; t_in = '0; t_par_in = 1'b0;
    tick(); tick();
    check("R9 reset flag", {15'd0, err_pull_low}, 16'd0);
    check("R4 idle oe", {14'd0, t_oe, r_oe}, 16'd0);
    rst_n = 1'b1;
    tick();

    // R1/R2 transmit sweep
    t_drv_n = 1'b0; r_drv_n = 1'b1;
    for (int d = 0; d < 256; d++) begin
      r_in = 8'(d); t_in = ~8'(d); t_par_in = 1'b0;
      #3;
      check("R1 tx data/oe", {6'd0, t_oe, r_oe, t_out}, {6'd0, 1'b1, 1'b0, 8'(d)});
      check("R2 tx odd parity", 16'(ones({t_par_out, t_out}) % 2), 16'd1);
    end
    tick();
    check("R10 tx keeps flag", {15'd0, err_pull_low}, 16'd0);

    // R5 diagnostic sweep
    t_drv_n = 1'b0; r_drv_n = 1'b0;
    for (int d = 0; d < 256; d++) begin
      r_in = 8'(d); t_in = 8'(255 - d); t_par_in = 1'b0;
      #3;
      check("R5 diag paths", {t_oe, r_oe, t_out, r_out[5:0]}, {2'b11, 8'(d), 6'(255 - d)});
      check("R5 diag even parity", 16'(ones({t_par_out, t_out}) % 2), 16'd0);
    end
    t_in = 8'h00; t_par_in = 1'b0;
    tick();
    check("R10 diag keeps flag", {15'd0, err_pull_low}, 16'd0);

    // R3/R6 receive sweep over all nine-bit words
    for (int v = 0; v < 512; v++) begin
      t_drv_n = 1'b1; r_drv_n = 1'b0;
      t_in = v[7:0]; t_par_in = v[8]; r_in = 8'h5A;
      #3;
      check("R3 rx data/oe", {6'd0, t_oe, r_oe, r_out}, {6'd0, 1'b0, 1'b1, v[7:0]});
      tick();
      check("R6 rx check", {15'd0, err_pull_low}, (ones(9'(v)) % 2 == 0) ? 16'd1 : 16'd0);
      clear_flag();
    end

    // R4 idle outputs and R10 idle hold
    t_drv_n = 1'b1; r_drv_n = 1'b1; r_in = 8'hFF; t_in = 8'h00; t_par_in = 1'b0;
    #3;
    check("R4 idle outputs", {6'd0, t_oe, r_oe, t_out | r_out}, 16'd0);
    check("R4 idle parity", {15'd0, t_par_out}, 16'd0);
    tick();
    check("R10 idle keeps flag clear", {15'd0, err_pull_low}, 16'd0);

    // R7 sticky
    r_drv_n = 1'b0; t_in = 8'h03; t_par_in = 1'b0;
    tick();
    check("R6 set", {15'd0, err_pull_low}, 16'd1);
    t_in = 8'h01; t_par_in = 1'b0;
    tick(); tick();
    check("R7 sticky good rx", {15'd0, err_pull_low}, 16'd1);
    t_drv_n = 1'b0; r_drv_n = 1'b1; t_in = 8'h01;
    tick();
    check("R7 sticky tx", {15'd0, err_pull_low}, 16'd1);
    t_drv_n = 1'b1; r_drv_n = 1'b1;
    tick();
    check("R7 sticky idle", {15'd0, err_pull_low}, 16'd1);

    // R8 clear priority over failure
    r_drv_n = 1'b0; t_in = 8'h00; t_par_in = 1'b0; clr_n = 1'b0;
    tick();
    check("R8 clear wins", {15'd0, err_pull_low}, 16'd0);
    clr_n = 1'b1;
    tick();
    check("R6 sets after clear", {15'd0, err_pull_low}, 16'd1);

    // R9 asynchronous reset
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check("R9 async reset", {15'd0, err_pull_low}, 16'd0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule